// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block closes the feedback path of a frequency synthesiser that uses an external two-modulus prescaler. The prescaler divides the oscillator by P or by P+1. Its output is the clock of this block. A main counter with a programmed count M and a swallow counter with a programmed count A run side by side. Together they set the ratio of one feedback period to the oscillator, which is N = M·P + A.

The block holds a modulus-control output. It asks for P+1 during the first A prescaler cycles of each period and for P during the remaining M−A cycles. A one-cycle feedback pulse marks the start of each period for the phase detector.

The programmed counts come from registers held elsewhere. The block samples them only when both counters reload together at the end of a period, so an update never tears a period in progress. Some example settings:
- P = 64, M = 343, A = 48 gives 22000.
- P = 64, M = 63, A = 0 gives the smallest ratio that still leaves every channel reachable, 4032.

Top module: `pswal_counter`

## Requirements
- R1: `m_val` is 10 bits and legal from 8 to 1023. `a_val` is 7 bits and legal from 0 to 127. A legal pair also has `m_val` greater than `a_val`.
- R2: One feedback period spans exactly M prescaler cycles, which is M·P + A oscillator cycles with an ideal P/P+1 prescaler.
- R3: `mod_ctl` is 1 (select P+1) during the first A prescaler cycles of each period and 0 (select P) during the remaining M−A cycles.
- R4: When the loaded A is 0, `mod_ctl` stays 0 for the whole period.
- R5: `m_val` and `a_val` are sampled only at the reload that starts a period. A change in the middle of a period has no effect on that period's length or modulus pattern, and takes effect from the next period.
- R6: `fv` is 1 for exactly the first prescaler cycle of each period and 0 otherwise.
- R7: `fv` and `mod_ctl` are registered and change only on a rising edge of `clk`. While `rst` is high they are 0. The first rising edge after `rst` falls starts a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output, clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| m_val | input | 10 | Main count M, sampled at reload |
| a_val | input | 7 | Swallow count A, sampled at reload |
| mod_ctl | output | 1 | Modulus select to prescaler: 1 = P+1, 0 = P |
| fv | output | 1 | Divided feedback pulse, high in first cycle of each period |

## Verification
The hardest behaviour to reach from the ports is the exact oscillator-cycle length of a period. That length only exists once `mod_ctl` is fed back into a prescaler.

The bench therefore closes the loop with a behavioural P/P+1 prescaler clocked by the oscillator. The model latches `mod_ctl` one oscillator cycle into each prescaler cycle. The bench then times consecutive `fv` rising edges and compares the result against M·P + A.

The hold-off of new counts is reached by rewriting `m_val` and `a_val` in the third cycle of a running period. The bench then measures both that period and the next one.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  // default sizes of the pulse-swallow divider
  localparam int unsigned MAIN_W_DEF  = 10;
  localparam int unsigned SWAL_W_DEF  = 7;
  localparam int unsigned MAIN_MIN_DEF = 8;
endpackage

// File: rtl/pswal_main_cnt.sv
module pswal_main_cnt #(
  parameter int unsigned M_W = pswal_pkg::MAIN_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] m_in,
  output logic           last,
  output logic           fv
);
  localparam logic [M_W-1:0] ONE = M_W'(1);

  // cycles left in the period, current one included
  logic [M_W-1:0] m_rem;

  assign last = (m_rem == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rem <= ONE;          // next edge reloads and opens a period
      fv    <= 1'b0;
    end else begin
      m_rem <= last ? m_in : (m_rem - ONE);
      fv    <= last;
    end
  end

  // R6: feedback pulse lasts one prescaler cycle
  p_fv_single_r6: assert property (@(posedge clk) disable iff (rst)
    fv |=> !fv);

endmodule

// File: rtl/pswal_swallow.sv
module pswal_swallow #(
  parameter int unsigned A_W = pswal_pkg::SWAL_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  output logic           mod_ctl
);
  localparam logic [A_W-1:0] ONE  = A_W'(1);
  localparam logic [A_W-1:0] ZERO = '0;

  // swallow cycles still owed, current one included
  logic [A_W-1:0] a_rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem   <= ZERO;
      mod_ctl <= 1'b0;
    end else if (load) begin
      a_rem   <= a_in;
      mod_ctl <= (a_in != ZERO);
    end else if (a_rem != ZERO) begin
      a_rem   <= a_rem - ONE;
      mod_ctl <= (a_rem > ONE);
    end else begin
      mod_ctl <= 1'b0;
    end
  end

  // R4: a zero swallow count keeps the prescaler at P
  p_zero_swallow_r4: assert property (@(posedge clk) disable iff (rst)
    (load && (a_in == ZERO)) |=> !mod_ctl);

endmodule

// File: rtl/pswal_counter.sv
module pswal_counter #(
  parameter int unsigned M_W   = pswal_pkg::MAIN_W_DEF,
  parameter int unsigned A_W   = pswal_pkg::SWAL_W_DEF,
  parameter int unsigned M_MIN = pswal_pkg::MAIN_MIN_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  output logic           mod_ctl,
  output logic           fv
);
  localparam logic [M_W-1:0] M_LO = M_W'(M_MIN);

  logic reload;

  pswal_main_cnt #(.M_W(M_W)) u_main (
    .clk  (clk),
    .rst  (rst),
    .m_in (m_val),
    .last (reload),
    .fv   (fv)
  );

  pswal_swallow #(.A_W(A_W)) u_swal (
    .clk     (clk),
    .rst     (rst),
    .load    (reload),
    .a_in    (a_val),
    .mod_ctl (mod_ctl)
  );

  // R1: counts sampled at a reload lie in the legal window
  p_legal_load_r1: assert property (@(posedge clk) disable iff (rst)
    reload |-> ((m_val >= M_LO) && (m_val > M_W'(a_val))));

  // R3: P+1 is never requested in the last cycle of a period
  p_mod_off_last_r3: assert property (@(posedge clk) disable iff (rst)
    reload |-> !mod_ctl);

  // R3: P+1 requests only begin at the start of a period
  p_mod_rise_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_ctl) |-> fv);

endmodule

// File: tb/pswal_counter_bench.sv
`timescale 1ns/1ps
module pswal_counter_bench;
  logic       vco = 1'b0;
  logic       psc_clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] m_val = 10'd8;
  logic [6:0] a_val = 7'd0;
  logic       mod_ctl, fv;

  int checks = 0;
  int errors = 0;
  int psc_p  = 8;
  int pc     = 0;
  int plen   = 8;
  int vcyc   = 0;
  bit done   = 1'b0;

  always #2 vco = ~vco;   // 250 MHz oscillator

  pswal_counter u_pswal_counter (
    .clk(psc_clk), .rst(rst), .m_val(m_val), .a_val(a_val),
    .mod_ctl(mod_ctl), .fv(fv)
  );

  // behavioural P/P+1 prescaler; length latched one oscillator cycle in
  always @(posedge vco) begin
    if (pc >= plen - 1) begin
      pc      <= 0;
      psc_clk <= 1'b1;
    end else begin
      pc <= pc + 1;
      if (pc == 0) plen <= mod_ctl ? psc_p + 1 : psc_p;
      if (pc + 1 == psc_p / 2) psc_clk <= 1'b0;
    end
  end

  always @(posedge vco) begin
    vcyc <= vcyc + 1;
    if (vcyc > 190000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d oscillator cycles expected completion", vcyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge psc_clk); rst = 1'b1;
    repeat (3) @(negedge psc_clk);
    rst = 1'b0;
  endtask

  // one period: checks modulus pattern and fv, returns length in oscillator cycles
  task automatic one_period(input int m, input int a, input int chg_at,
                            input int m2, input int a2,
                            output int bad_mod, output int bad_fv, output longint n);
    time t1, t2;
    t1 = $time; bad_mod = 0; bad_fv = 0;
    for (int k = 0; k < m; k++) begin
      @(negedge psc_clk);
      if (mod_ctl !== (k < a)) bad_mod++;
      if (fv !== (k == 0)) bad_fv++;
      if (k == chg_at) begin m_val = 10'(m2); a_val = 7'(a2); end
    end
    @(posedge fv);
    t2 = $time;
    n = longint'((t2 - t1) / 4);
  endtask

  localparam int VEC [8][4] = '{
    '{8, 8, 0, 64},     '{8, 8, 7, 71},
    '{8, 10, 3, 83},    '{16, 20, 15, 335},
    '{64, 343, 48, 22000}, '{64, 63, 0, 4032},
    '{8, 1023, 5, 8189}, '{4, 9, 2, 38}
  };

  initial begin
    int bm, bf;
    longint n;
    // R7: reset state with a nonzero swallow count loaded
    psc_p = 8; m_val = 10'd10; a_val = 7'd3;
    repeat (3) @(negedge psc_clk);
    check(fv === 1'b0, "R7 fv in reset", fv, 0);
    check(mod_ctl === 1'b0, "R7 mod_ctl in reset", mod_ctl, 0);
    rst = 1'b0;
    @(negedge psc_clk);
    check(fv === 1'b1, "R7 first edge opens period", fv, 1);
    check(mod_ctl === 1'b1, "R7 first cycle swallow", mod_ctl, 1);

    for (int i = 0; i < 8; i++) begin
      psc_p = VEC[i][0]; m_val = 10'(VEC[i][1]); a_val = 7'(VEC[i][2]);
      do_reset();
      @(posedge fv);
      one_period(VEC[i][1], VEC[i][2], -1, 0, 0, bm, bf, n);
      check(n == VEC[i][3], "R2 period length", n, VEC[i][3]);
      if (VEC[i][2] == 0) check(bm == 0, "R4 mod_ctl low all period", bm, 0);
      else check(bm == 0, "R3 modulus pattern mismatches", bm, 0);
      check(bf == 0, "R6 fv pattern mismatches", bf, 0);
    end

    // R5: counts rewritten mid-period apply only from the next period
    psc_p = 8; m_val = 10'd10; a_val = 7'd3;
    do_reset();
    @(posedge fv);
    one_period(10, 3, 2, 20, 9, bm, bf, n);
    check(n == 83, "R5 current period unchanged", n, 83);
    check(bm == 0, "R5 current modulus pattern unchanged", bm, 0);
    one_period(20, 9, -1, 0, 0, bm, bf, n);
    check(n == 169, "R5 next period uses new counts", n, 169);
    check(bm == 0, "R5 next modulus pattern", bm, 0);
    check(bf == 0, "R6 fv after update", bf, 0);

    // R7: reset raised while swallowing clears outputs at the next edge
    @(negedge psc_clk);
    check(mod_ctl === 1'b1, "R3 swallow active in cycle 1", mod_ctl, 1);
    rst = 1'b1;
    @(negedge psc_clk);
    check(mod_ctl === 1'b0, "R7 mid-run reset mod_ctl", mod_ctl, 0);
    check(fv === 1'b0, "R7 mid-run reset fv", fv, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule